// File: doc/BRIEF.md
# Serial Result Transmitter with Start Marker

This block is the output side of a converter, built as a partner against which a serial reader can be verified. It keeps a 16-bit result and shifts it out MSB first on a continuous data clock supplied by the reader. A single-pulse start marker comes one clock ahead of the first data bit. Nothing analog is modelled. A convert request starts a programmable timer that pulls the busy line low. When the timer expires, the most recently strobed input word becomes the new result.

Every input is sampled on the rising edge of the data clock, and every output is a register that changes only on that edge. Each edge is one of four kinds, set by the chip-select, read/convert-select and busy levels: hold (select high), convert-select (select low, read/convert low), read (select low, read/convert high, busy high) and wait (select low, read/convert high, busy low). Hold and convert-select edges arm the marker. Read edges drive the transfer. Any other kind of edge ends a transfer that is in progress.

Top module: `serial_result_tx`

## Requirements
- R1: While `rst_n` is low, `busy` is 1 and `sync` and `sdata` are 0.
- R2: A hold or convert-select edge arms the marker. The first read edge after arming is pulse 1, and after it `sync` is 1 for exactly one edge period, with `sdata` at 0. That read edge disarms the marker.
- R3: Read edges that come while the marker is not armed and no transfer is active leave `sync` and `sdata` at 0.
- R4: After read pulse p of an armed transfer, with p from 2 to 17, `sdata` equals result bit (17 - p). The MSB is therefore sent first, after pulse 2, and bit 0 is sent after pulse 17.
- R5: From read pulse 18 onward, `sdata` is 0 and `sync` stays 0 until the marker is armed again.
- R6: A rising edge at which `rc_sel` is 0, `cs_n` is 0 and `busy` is 1, with `rc_sel` sampled at 1 on the previous edge, is a convert start. After it `busy` is 0 for `conv_len` edges, or for one edge when `conv_len` is 0. A falling `rc_sel` while `busy` is 0 neither restarts nor extends the timer.
- R7: On the edge where `busy` returns to 1, the result becomes the last `load_word` that was presented with `load_stb` high on an earlier edge. Later reads send that value.
- R8: A hold edge during a transfer returns `sync` and `sdata` to 0 on that edge and cancels the transfer. The next transfer starts again with a new marker and the full word.
- R9: While `busy` is 0, `sync` and `sdata` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dclk | input | 1 | Continuous data clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rc_sel | input | 1 | 1 selects read, 0 selects convert |
| load_stb | input | 1 | Captures `load_word` as the pending result |
| load_word | input | 16 | Word that the next completed conversion will publish |
| conv_len | input | 8 | Conversion length in data-clock edges, sampled at convert start |
| sdata | output | 1 | Serial data, MSB first |
| sync | output | 1 | One-pulse marker ahead of the MSB |
| busy | output | 1 | 0 while a conversion is running |

## Verification
On every cycle the assertions check the following: `sync` never lasts more than one period, and it rises only on an armed read edge. The marker is disarmed whenever `sync` is high. The serial lines stay quiet while busy is low or chip select is high. A convert start drops busy, and timer expiry raises it. Only the bench scenarios can show the rest: the bit order and the exact pulse where each bit appears, the exact conversion length, that a second falling `rc_sel` during a conversion is ignored, which strobed word gets published, and that a cancelled transfer restarts from the marker.

// File: rtl/serial_result_tx_pkg.sv
package serial_result_tx_pkg;

  // Kind of a data-clock edge, decided from the control levels at that edge.
  typedef enum logic [1:0] {
    EDGE_HOLD = 2'd0,  // select deasserted
    EDGE_CONV = 2'd1,  // select asserted, convert chosen
    EDGE_READ = 2'd2,  // select asserted, read chosen, result ready
    EDGE_WAIT = 2'd3   // select asserted, read chosen, conversion running
  } edge_kind_e;

  function automatic edge_kind_e classify(logic cs_n, logic rc_sel, logic busy);
    if (cs_n)         return EDGE_HOLD;
    else if (!rc_sel) return EDGE_CONV;
    else if (busy)    return EDGE_READ;
    else              return EDGE_WAIT;
  endfunction

  function automatic logic arms_marker(edge_kind_e k);
    return (k == EDGE_HOLD) || (k == EDGE_CONV);
  endfunction

endpackage

// File: rtl/serial_result_tx_arm.sv
module serial_result_tx_arm
  import serial_result_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  edge_kind_e kind,
  input  logic       consume,
  output logic       armed
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  armed <= 1'b0;
    else if (arms_marker(kind))  armed <= 1'b1;
    else if (consume)            armed <= 1'b0;
  end

endmodule

// File: rtl/serial_result_tx_conv.sv
module serial_result_tx_conv #(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] conv_len,
  input  logic          load_stb,
  input  logic [W-1:0]  load_word,
  output logic          busy,
  output logic          done_evt,
  output logic [W-1:0]  result
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  stage;

  function automatic logic [CW-1:0] eff_len(logic [CW-1:0] len);
    return (len == '0) ? ONE : len;
  endfunction

  assign done_evt = !busy && (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage <= '0;
    else if (load_stb) stage <= load_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b1;
      cnt    <= '0;
      result <= '0;
    end else if (start) begin
      busy <= 1'b0;
      cnt  <= eff_len(conv_len);
    end else if (done_evt) begin
      busy   <= 1'b1;
      result <= stage;
    end else if (!busy) begin
      cnt <= cnt - ONE;
    end
  end

endmodule

// File: rtl/serial_result_tx_shift.sv
module serial_result_tx_shift
  import serial_result_tx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  edge_kind_e   kind,
  input  logic         armed,
  input  logic [W-1:0] result,
  output logic         consume,
  output logic         active,
  output logic         sync,
  output logic         sdata
);

  localparam int              PW     = $clog2(W + 3);
  localparam logic [PW-1:0]   LAST_P = PW'(W + 2);

  logic [PW-1:0] pcnt;
  logic [PW-1:0] nxt;

  // Data bit that belongs after read pulse p: MSB at pulse 2, LSB at pulse W+1.
  function automatic logic pick(logic [W-1:0] w, int p);
    logic [W-1:0] sh;
    if (p < 2 || p > W + 1) return 1'b0;
    sh = w << (p - 2);
    return sh[W-1];
  endfunction

  assign nxt     = pcnt + 1'b1;
  assign consume = (kind == EDGE_READ) && !active && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pcnt   <= '0;
      sync   <= 1'b0;
      sdata  <= 1'b0;
    end else if (kind == EDGE_READ) begin
      if (active) begin
        pcnt  <= nxt;
        sync  <= 1'b0;
        sdata <= pick(result, int'(nxt));
        if (nxt == LAST_P) active <= 1'b0;
      end else if (armed) begin
        active <= 1'b1;
        pcnt   <= PW'(1);
        sync   <= 1'b1;
        sdata  <= 1'b0;
      end else begin
        sync  <= 1'b0;
        sdata <= 1'b0;
      end
    end else begin
      active <= 1'b0;
      pcnt   <= '0;
      sync   <= 1'b0;
      sdata  <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_result_tx.sv
module serial_result_tx
  import serial_result_tx_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input  logic          dclk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rc_sel,
  input  logic          load_stb,
  input  logic [W-1:0]  load_word,
  input  logic [CW-1:0] conv_len,
  output logic          sdata,
  output logic          sync,
  output logic          busy
);

  edge_kind_e   kind;
  logic         rc_q;
  logic         start_evt;
  logic         done_evt;
  logic         armed;
  logic         consume;
  logic         active;
  logic [W-1:0] result;

  assign kind      = classify(cs_n, rc_sel, busy);
  assign start_evt = rc_q && !rc_sel && !cs_n && busy;

  always_ff @(posedge dclk or negedge rst_n) begin
    if (!rst_n) rc_q <= 1'b0;
    else        rc_q <= rc_sel;
  end

  serial_result_tx_arm u_arm (
    .clk     (dclk),
    .rst_n   (rst_n),
    .kind    (kind),
    .consume (consume),
    .armed   (armed)
  );

  serial_result_tx_conv #(.W(W), .CW(CW)) u_conv (
    .clk       (dclk),
    .rst_n     (rst_n),
    .start     (start_evt),
    .conv_len  (conv_len),
    .load_stb  (load_stb),
    .load_word (load_word),
    .busy      (busy),
    .done_evt  (done_evt),
    .result    (result)
  );

  serial_result_tx_shift #(.W(W)) u_shift (
    .clk     (dclk),
    .rst_n   (rst_n),
    .kind    (kind),
    .armed   (armed),
    .result  (result),
    .consume (consume),
    .active  (active),
    .sync    (sync),
    .sdata   (sdata)
  );

endmodule

// File: rtl/serial_result_tx_chk.sv
module serial_result_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic rc_sel,
  input logic busy,
  input logic sync,
  input logic sdata,
  input logic armed,
  input logic start_evt,
  input logic done_evt
);

  a_r2_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> !sync);

  a_r2_sync_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> ($past(armed) && $past(!cs_n && rc_sel)));

  a_r5_disarmed_at_sync: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> !armed);

  a_r9_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sync && !sdata));

  a_r8_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!sync && !sdata));

  a_r6_start_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !busy);

  a_r7_done_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> busy);

endmodule

bind serial_result_tx serial_result_tx_chk u_chk (
  .clk       (dclk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .rc_sel    (rc_sel),
  .busy      (busy),
  .sync      (sync),
  .sdata     (sdata),
  .armed     (armed),
  .start_evt (start_evt),
  .done_evt  (done_evt)
);

// File: tb/serial_result_tx_test.sv
`timescale 1ns/1ps
module serial_result_tx_test;

  logic        dclk = 1'b0;
  logic        rst_n;
  logic        cs_n, rc_sel, load_stb;
  logic [15:0] load_word;
  logic [7:0]  conv_len;
  logic        sdata, sync, busy;
  int          total = 0;
  int          bad   = 0;

  always #4 dclk = ~dclk;

  serial_result_tx uut (
    .dclk(dclk), .rst_n(rst_n), .cs_n(cs_n), .rc_sel(rc_sel),
    .load_stb(load_stb), .load_word(load_word), .conv_len(conv_len),
    .sdata(sdata), .sync(sync), .busy(busy)
  );

  // Expected serial bit after armed read pulse p.
  function automatic logic want_bit(logic [15:0] w, int p);
    if (p < 2 || p > 17) return 1'b0;
    return (w >> (17 - p)) & 16'h1;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive levels, let one rising edge pass, return at the falling edge.
  task automatic tick(logic c, logic r);
    cs_n   = c;
    rc_sel = r;
    @(negedge dclk);
    load_stb = 1'b0;
  endtask

  task automatic strobe(logic [15:0] w);
    load_word = w;
    load_stb  = 1'b1;
    tick(1'b1, 1'b1);
  endtask

  task automatic convert(int len);
    int eff;
    eff = (len == 0) ? 1 : len;
    conv_len = len[7:0];
    tick(1'b1, 1'b1);
    tick(1'b0, 1'b0);
    chk("R6 busy low at start", busy, 0);
    for (int k = 1; k < eff; k++) begin
      tick(1'b0, 1'b1);
      chk("R6 busy still low", busy, 0);
      chk("R9 quiet while busy", {sync, sdata}, 0);
    end
    tick(1'b0, 1'b1);
    chk("R6 busy back high", busy, 1);
  endtask

  task automatic read(logic [15:0] w, int n, bit marked);
    for (int p = 1; p <= n; p++) begin
      tick(1'b0, 1'b1);
      chk(marked ? "R2 sync pulse" : "R3 no sync unarmed", sync, (marked && p == 1) ? 1 : 0);
      if (!marked)     chk("R3 data quiet", sdata, 0);
      else if (p > 17) chk("R5 data zero after LSB", sdata, 0);
      else             chk("R4 data bit", sdata, want_bit(w, p));
    end
  endtask

  initial begin
    repeat (150000) @(posedge dclk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] w, w2;
    process::self().srandom(32'd4242);
    rst_n = 1'b0; cs_n = 1'b1; rc_sel = 1'b1; load_stb = 1'b0;
    load_word = '0; conv_len = 8'd3;
    repeat (3) @(negedge dclk);
    chk("R1 busy in reset", busy, 1);
    chk("R1 lines in reset", {sync, sdata}, 0);
    rst_n = 1'b1;

    // random conversions and reads
    for (int i = 0; i < 25; i++) begin
      w = 16'($urandom);
      strobe(w);
      convert(int'($urandom_range(0, 12)));
      read(w, 20, 1'b1);
    end

    // corner words
    strobe(16'h8000); convert(2); read(16'h8000, 19, 1'b1);
    strobe(16'h0001); convert(1); read(16'h0001, 19, 1'b1);

    // R3/R5: staying in the read window does not give a second marker
    w = 16'hA5C3;
    strobe(w); convert(4); read(w, 19, 1'b1);
    read(w, 6, 1'b0);
    // R2: re-arm with a hold edge and read the same word again
    tick(1'b1, 1'b1);
    read(w, 19, 1'b1);

    // R8: cancel mid-word with a hold edge, then restart from the marker
    tick(1'b1, 1'b1);
    read(w, 8, 1'b1);
    tick(1'b1, 1'b1);
    chk("R8 lines zero on cancel", {sync, sdata}, 0);
    read(w, 19, 1'b1);

    // R6: a second falling rc_sel during busy is ignored (len 5)
    conv_len = 8'd5;
    tick(1'b1, 1'b1);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    chk("R6 busy low before expiry", busy, 0);
    tick(1'b0, 1'b1);
    chk("R6 no restart from second fall", busy, 1);
    read(w, 19, 1'b1);

    // R6: zero length behaves as one edge
    convert(0);

    // R7: word strobed during the conversion is the one published
    w  = 16'h1234;
    w2 = 16'hBEEF;
    strobe(w);
    conv_len = 8'd4;
    tick(1'b1, 1'b1);
    tick(1'b0, 1'b0);
    load_word = w2; load_stb = 1'b1;
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    chk("R7 busy low", busy, 0);
    tick(1'b0, 1'b1);
    chk("R7 busy high", busy, 1);
    read(w2, 19, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule